// File: doc/BRIEF.md
# Exception Entry Vector Sequencer

This block decides how a processor core enters an exception or interrupt handler. Each cycle in which it is idle it examines a pending exception code, a hardware interrupt request (with a flag from the interrupt controller saying whether some source beats the current mask level, and that source's vector), the core's status word, PC, R15, the vector base and a delay-slot indication. When an entry is due it computes the handler address, the new status word and the values to save (status, PC and R15), and commits all of them on a single clock edge.

The sequencer is a two-state machine. In state `ST_IDLE` it evaluates requests. The transition `ST_IDLE -> ST_COMMIT` fires when an exception is pending, or when an interrupt is allowed. In `ST_COMMIT` the `taken` pulse is high, the committed values are presented and requests are not examined. The transition `ST_COMMIT -> ST_IDLE` is unconditional. The core is expected to drop or replace its request in the commit cycle. Registered results hold their values until the next entry.

Status word bit positions, which the core decodes: FD = bit 15, IMASK = bits 7:4, BL (block) = bit 28, RB = bit 29, MD = bit 30.

Top module: `exc_entry_seq`

## Requirements
- R1: An exception that is pending wins over any interrupt. In that entry `expevt_we` pulses and `intevt_we` stays low.
- R2: While BL (`sr_in[28]`) is set, a pending exception with any code other than 0x1E0 is entered as code 0x000. Code 0x1E0 keeps its own code and goes to the base + 0x100.
- R3: While BL is set, an interrupt is not entered unless `halted` is high. An interrupt entered while `halted` is high raises `halt_clr` in the commit cycle.
- R4: An interrupt is entered only when `irq_req` and `irq_hit` are both high. Otherwise the outputs do not change.
- R5: On every entry, `ssr_out` is the prior `sr_in` and `sgr_out` is `r15_in`. `sr_out` has BL, RB and MD (bits 28, 29, 30) set.
- R6: When `in_dslot` is high, the saved PC is `pc_in - 2` and `dslot_clr` pulses in the commit cycle.
- R7: Exception codes 0x000, 0x020 and 0x140 go to PC 0xA0000000. These codes also clear FD (bit 15) and set IMASK (bits 7:4) to 0xF.
- R8: Exception codes 0x040 and 0x060 go to `vbr_in + 0x400`. Every other exception code goes to `vbr_in + 0x100`. Every exception writes its entered code to `expevt_out`.
- R9: Code 0x160 saves `pc_in + 2`, or `pc_in` when it also sits in a delay slot.
- R10: An interrupt writes `irq_vec` to `intevt_out`, pulses `intevt_we` and goes to `vbr_in + 0x600`.
- R11: `taken` is a one-cycle pulse. All outputs change on the edge that raises it. A request still present during the commit cycle is not evaluated there.
- R12: After reset, `taken` and all write and clear pulses are low, and every data output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_pend | input | 1 | An exception code is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Hardware interrupt request |
| irq_hit | input | 1 | Controller found a source above the current mask |
| irq_vec | input | 12 | Vector of that source |
| halted | input | 1 | Core is halted waiting for an interrupt |
| in_dslot | input | 1 | Current instruction sits in a delay slot |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current PC |
| r15_in | input | 32 | Current R15 |
| vbr_in | input | 32 | Vector base |
| taken | output | 1 | One-cycle entry pulse |
| pc_out | output | 32 | Handler address |
| sr_out | output | 32 | New status word |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved PC |
| sgr_out | output | 32 | Saved R15 |
| expevt_out | output | 12 | Entered exception code |
| expevt_we | output | 1 | Exception code written |
| intevt_out | output | 12 | Entered interrupt vector |
| intevt_we | output | 1 | Interrupt vector written |
| halt_clr | output | 1 | Clear the halt flag |
| dslot_clr | output | 1 | Clear the delay-slot flags |

## Verification
The assertions assume that `irq_hit` was already computed by the controller from the IMASK field of the same `sr_in`. They also assume that the status and PC inputs are steady during the idle cycle in which a request is evaluated. The stimulus holds every input constant from one falling edge to the next, and supplies `irq_hit` as a free flag rather than deriving it from a mask. Apart from the held-request case, it drops the request in the commit cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN   = 32;
    localparam int CODE_W = 12;

    // status word bit positions decoded by the core
    localparam int SR_FD_BIT  = 15;
    localparam int SR_BL_BIT  = 28;
    localparam int SR_RB_BIT  = 29;
    localparam int SR_MD_BIT  = 30;
    localparam int IMASK_LO   = 4;
    localparam int IMASK_W    = 4;

    localparam logic [CODE_W-1:0] CODE_POWERON = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MANUAL  = 12'h020;
    localparam logic [CODE_W-1:0] CODE_MULTI   = 12'h140;
    localparam logic [CODE_W-1:0] CODE_MISS_RD = 12'h040;
    localparam logic [CODE_W-1:0] CODE_MISS_WR = 12'h060;
    localparam logic [CODE_W-1:0] CODE_TRAP    = 12'h160;
    localparam logic [CODE_W-1:0] CODE_UNBLOCK = 12'h1E0;

    localparam logic [XLEN-1:0] RESET_TARGET = 32'hA000_0000;
    localparam int OFS_GENERAL = 'h100;
    localparam int OFS_MISS    = 'h400;
    localparam int OFS_IRQ     = 'h600;
    localparam int INSN_BYTES  = 2;

    typedef enum logic [1:0] {
        ENT_NONE = 2'd0,
        ENT_EXC  = 2'd1,
        ENT_IRQ  = 2'd2
    } entry_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } seq_state_e;

    function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
        return (c == CODE_POWERON) || (c == CODE_MANUAL) || (c == CODE_MULTI);
    endfunction

    function automatic logic is_miss_class(input logic [CODE_W-1:0] c);
        return (c == CODE_MISS_RD) || (c == CODE_MISS_WR);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          exc_pend,
    input  logic [CW-1:0] exc_code,
    input  logic          irq_req,
    input  logic          irq_hit,
    input  logic [CW-1:0] irq_vec,
    input  logic          halted,
    input  logic          blocked,
    output entry_kind_e   kind,
    output logic [CW-1:0] eff_code
);

    always_comb begin
        kind     = ENT_NONE;
        eff_code = exc_code;
        if (exc_pend) begin
            kind = ENT_EXC;
            if (blocked && (exc_code != CW'(CODE_UNBLOCK))) begin
                eff_code = CW'(CODE_POWERON);
            end
        end else if (irq_req && irq_hit && (!blocked || halted)) begin
            kind     = ENT_IRQ;
            eff_code = irq_vec;
        end
    end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_entry_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = CODE_W
) (
    input  entry_kind_e   kind,
    input  logic [CW-1:0] eff_code,
    input  logic [XW-1:0] sr,
    input  logic [XW-1:0] pc,
    input  logic [XW-1:0] vbr,
    input  logic          in_dslot,
    output logic [XW-1:0] next_pc,
    output logic [XW-1:0] next_sr,
    output logic [XW-1:0] saved_pc
);

    localparam logic [XW-1:0] STEP = XW'(INSN_BYTES);

    logic is_exc;
    logic rst_cls;
    logic is_trap;
    logic [XW-1:0] back;
    logic [XW-1:0] fwd;

    assign is_exc  = (kind == ENT_EXC);
    assign rst_cls = is_exc && is_reset_class(eff_code);
    assign is_trap = is_exc && (eff_code == CW'(CODE_TRAP));

    always_comb begin
        back     = in_dslot ? STEP : '0;
        fwd      = is_trap ? STEP : '0;
        saved_pc = pc - back + fwd;
    end

    always_comb begin
        next_sr            = sr;
        next_sr[SR_BL_BIT] = 1'b1;
        next_sr[SR_RB_BIT] = 1'b1;
        next_sr[SR_MD_BIT] = 1'b1;
        if (rst_cls) begin
            next_sr[SR_FD_BIT]                 = 1'b0;
            next_sr[IMASK_LO +: IMASK_W]       = '1;
        end
    end

    always_comb begin
        if (kind == ENT_IRQ) begin
            next_pc = vbr + XW'(OFS_IRQ);
        end else if (rst_cls) begin
            next_pc = RESET_TARGET;
        end else if (is_exc && is_miss_class(eff_code)) begin
            next_pc = vbr + XW'(OFS_MISS);
        end else begin
            next_pc = vbr + XW'(OFS_GENERAL);
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_pend,
    input  logic [CW-1:0] exc_code,
    input  logic          irq_req,
    input  logic          irq_hit,
    input  logic [CW-1:0] irq_vec,
    input  logic          halted,
    input  logic          in_dslot,
    input  logic [XW-1:0] sr_in,
    input  logic [XW-1:0] pc_in,
    input  logic [XW-1:0] r15_in,
    input  logic [XW-1:0] vbr_in,
    output logic          taken,
    output logic [XW-1:0] pc_out,
    output logic [XW-1:0] sr_out,
    output logic [XW-1:0] ssr_out,
    output logic [XW-1:0] spc_out,
    output logic [XW-1:0] sgr_out,
    output logic [CW-1:0] expevt_out,
    output logic          expevt_we,
    output logic [CW-1:0] intevt_out,
    output logic          intevt_we,
    output logic          halt_clr,
    output logic          dslot_clr
);

    seq_state_e  state, state_nx;
    entry_kind_e kind, kind_q;
    logic [CW-1:0] eff_code;
    logic [XW-1:0] calc_pc, calc_sr, calc_spc;
    logic halt_q, ds_q;
    logic accept;

    exc_arbiter #(.CW(CW)) u_arb (
        .exc_pend (exc_pend),
        .exc_code (exc_code),
        .irq_req  (irq_req),
        .irq_hit  (irq_hit),
        .irq_vec  (irq_vec),
        .halted   (halted),
        .blocked  (sr_in[SR_BL_BIT]),
        .kind     (kind),
        .eff_code (eff_code)
    );

    exc_vector_calc #(.XW(XW), .CW(CW)) u_vec (
        .kind     (kind),
        .eff_code (eff_code),
        .sr       (sr_in),
        .pc       (pc_in),
        .vbr      (vbr_in),
        .in_dslot (in_dslot),
        .next_pc  (calc_pc),
        .next_sr  (calc_sr),
        .saved_pc (calc_spc)
    );

    assign accept = (state == ST_IDLE) && (kind != ENT_NONE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (kind != ENT_NONE) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= ENT_NONE;
            pc_out     <= '0;
            sr_out     <= '0;
            ssr_out    <= '0;
            spc_out    <= '0;
            sgr_out    <= '0;
            expevt_out <= '0;
            intevt_out <= '0;
            halt_q     <= 1'b0;
            ds_q       <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind;
            pc_out  <= calc_pc;
            sr_out  <= calc_sr;
            ssr_out <= sr_in;
            spc_out <= calc_spc;
            sgr_out <= r15_in;
            if (kind == ENT_EXC) expevt_out <= eff_code;
            if (kind == ENT_IRQ) intevt_out <= eff_code;
            halt_q  <= (kind == ENT_IRQ) && halted;
            ds_q    <= in_dslot;
        end
    end

    always_comb begin
        taken     = (state == ST_COMMIT);
        expevt_we = taken && (kind_q == ENT_EXC);
        intevt_we = taken && (kind_q == ENT_IRQ);
        halt_clr  = taken && halt_q;
        dslot_clr = taken && ds_q;
    end

    assert_exc_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && exc_pend) |=> (expevt_we && !intevt_we));

    assert_blocked_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && exc_pend && sr_in[SR_BL_BIT] && exc_code != CW'(CODE_UNBLOCK))
        |=> (expevt_out == '0));

    assert_blocked_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !exc_pend && sr_in[SR_BL_BIT] && !halted) |=> !taken);

    assert_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !exc_pend && !irq_hit) |=> (!taken && $stable(pc_out)));

    assert_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (ssr_out == $past(sr_in) && sr_out[SR_BL_BIT] && sr_out[SR_RB_BIT]
                   && sr_out[SR_MD_BIT]));

    assert_irq_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        intevt_we |-> (pc_out == $past(vbr_in) + XW'(OFS_IRQ) && $stable(expevt_out)));

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_pend = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic        irq_hit = 1'b0;
    logic [11:0] irq_vec = '0;
    logic        halted = 1'b0;
    logic        in_dslot = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic        taken, expevt_we, intevt_we, halt_clr, dslot_clr;
    logic [31:0] pc_out, sr_out, ssr_out, spc_out, sgr_out;
    logic [11:0] expevt_out, intevt_out;

    always #2 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .exc_pend(exc_pend), .exc_code(exc_code),
        .irq_req(irq_req), .irq_hit(irq_hit), .irq_vec(irq_vec), .halted(halted),
        .in_dslot(in_dslot), .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in),
        .vbr_in(vbr_in), .taken(taken), .pc_out(pc_out), .sr_out(sr_out),
        .ssr_out(ssr_out), .spc_out(spc_out), .sgr_out(sgr_out),
        .expevt_out(expevt_out), .expevt_we(expevt_we), .intevt_out(intevt_out),
        .intevt_we(intevt_we), .halt_clr(halt_clr), .dslot_clr(dslot_clr)
    );

    typedef struct {
        logic [31:0] pc, sr, ssr, spc, sgr;
        logic [11:0] code;
        logic        ew, iw, hc, dc;
        int          req;
    } item_t;

    item_t q[$];
    int tests = 0;
    int fails = 0;
    logic [31:0] last_pc = '0;
    bit done = 0;

    task automatic check(input string what, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // independent reference of the entry rules
    function automatic bit model(input logic ep, input logic [11:0] ec, input logic ir,
        input logic ih, input logic [11:0] iv, input logic hl, input logic ds,
        input logic [31:0] sr, input logic [31:0] pc, input logic [31:0] r15,
        input logic [31:0] vbr, input int req, output item_t it);
        logic bl;
        logic [11:0] c;
        bl = sr[28];
        it.req = req; it.ssr = sr; it.sgr = r15; it.dc = ds; it.hc = 0;
        it.ew = 0; it.iw = 0; it.code = '0;
        it.sr = sr | 32'h7000_0000;
        it.spc = ds ? pc - 32'd2 : pc;
        it.pc = '0;
        if (ep) begin
            c = (bl && ec != 12'h1E0) ? 12'h000 : ec;
            it.ew = 1; it.code = c;
            if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
                it.pc = 32'hA000_0000;
                it.sr = (it.sr & ~32'h0000_8000) | 32'h0000_00F0;
            end else if (c == 12'h040 || c == 12'h060) it.pc = vbr + 32'h400;
            else it.pc = vbr + 32'h100;
            if (c == 12'h160) it.spc = it.spc + 32'd2;
            return 1;
        end
        if (ir && ih && (!bl || hl)) begin
            it.iw = 1; it.code = iv; it.hc = hl; it.pc = vbr + 32'h600;
            return 1;
        end
        return 0;
    endfunction

    task automatic entry(input logic ep, input logic [11:0] ec, input logic ir,
        input logic ih, input logic [11:0] iv, input logic hl, input logic ds,
        input logic [31:0] sr, input logic [31:0] pc, input int req);
        item_t it;
        @(negedge clk);
        exc_pend = ep; exc_code = ec; irq_req = ir; irq_hit = ih; irq_vec = iv;
        halted = hl; in_dslot = ds; sr_in = sr; pc_in = pc;
        r15_in = pc ^ 32'h5A5A_0000; vbr_in = 32'h8C00_0000 + {pc[15:0], 4'h0};
        if (model(ep, ec, ir, ih, iv, hl, ds, sr, pc, r15_in, vbr_in, req, it)) begin
            q.push_back(it);
            last_pc = it.pc;
        end
        @(negedge clk);
        exc_pend = 0; irq_req = 0;
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && taken) begin
            if (q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R4 unexpected entry: actual taken=1 expected taken=0 pc %h", pc_out);
            end else begin
                item_t e;
                e = q.pop_front();
                check("pc", e.req, pc_out, e.pc);
                check("sr", e.req, sr_out, e.sr);
                check("ssr", 5, ssr_out, e.ssr);
                check("spc", e.req, spc_out, e.spc);
                check("sgr", 5, sgr_out, e.sgr);
                check("expevt_we", e.req, {31'd0, expevt_we}, {31'd0, e.ew});
                check("intevt_we", e.req, {31'd0, intevt_we}, {31'd0, e.iw});
                if (e.ew) check("expevt", e.req, {20'd0, expevt_out}, {20'd0, e.code});
                if (e.iw) check("intevt", e.req, {20'd0, intevt_out}, {20'd0, e.code});
                check("halt_clr", e.req, {31'd0, halt_clr}, {31'd0, e.hc});
                check("dslot_clr", e.req, {31'd0, dslot_clr}, {31'd0, e.dc});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("taken after reset", 12, {31'd0, taken}, 32'd0);
        check("pc after reset", 12, pc_out, 32'd0);
        check("pulses after reset", 12,
              {28'd0, expevt_we, intevt_we, halt_clr, dslot_clr}, 32'd0);

        // R8: general and miss vectors
        entry(1, 12'h0E0, 0, 0, 0, 0, 0, 32'h0000_0030, 32'h0C00_1000, 8);
        entry(1, 12'h040, 0, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_2002, 8);
        entry(1, 12'h060, 0, 0, 0, 0, 0, 32'h0000_0010, 32'h0C00_3004, 8);
        // R7: reset-class codes
        entry(1, 12'h020, 0, 0, 0, 0, 0, 32'h0000_8030, 32'h0C00_4000, 7);
        entry(1, 12'h140, 0, 0, 0, 0, 0, 32'h0000_8000, 32'h0C00_4100, 7);
        // R9: trap advances saved PC
        entry(1, 12'h160, 0, 0, 0, 0, 0, 32'h0000_0000, 32'h0C00_5000, 9);
        // R6: delay slot backs up saved PC
        entry(1, 12'h180, 0, 0, 0, 0, 1, 32'h0000_0000, 32'h0C00_6006, 6);
        entry(1, 12'h160, 0, 0, 0, 0, 1, 32'h0000_0000, 32'h0C00_6100, 9);
        // R2: blocked exceptions
        entry(1, 12'h0A0, 0, 0, 0, 0, 0, 32'h1000_0000, 32'h0C00_7000, 2);
        entry(1, 12'h1E0, 0, 0, 0, 0, 0, 32'h1000_0000, 32'h0C00_7100, 2);
        // R1: exception beats interrupt
        entry(1, 12'h180, 1, 1, 12'h320, 0, 0, 32'h0000_0000, 32'h0C00_8000, 1);
        // R10: plain interrupt
        entry(0, 12'h000, 1, 1, 12'h2A0, 0, 0, 32'h0000_0050, 32'h0C00_9000, 10);
        // R4: no source above mask; outputs must not move
        entry(0, 12'h000, 1, 0, 12'h3C0, 0, 0, 32'h0000_0000, 32'h0C00_A000, 4);
        check("pc held without hit", 4, pc_out, last_pc);
        // R3: blocked interrupt ignored unless halted
        entry(0, 12'h000, 1, 1, 12'h400, 0, 0, 32'h1000_0000, 32'h0C00_B000, 3);
        check("pc held while blocked", 3, pc_out, last_pc);
        entry(0, 12'h000, 1, 1, 12'h420, 1, 0, 32'h1000_0000, 32'h0C00_B100, 3);
        // R5: save values in another pattern
        entry(1, 12'h100, 0, 0, 0, 0, 0, 32'h4000_00F3, 32'h0C00_C000, 5);

        // R11: request held across the commit cycle gives a single pulse
        begin
            item_t it;
            @(negedge clk);
            exc_pend = 1; exc_code = 12'h180; irq_req = 0; halted = 0; in_dslot = 0;
            sr_in = 32'h0; pc_in = 32'h0C00_D000; r15_in = 32'h1234_5678;
            vbr_in = 32'h8C00_0000;
            if (model(1, 12'h180, 0, 0, 0, 0, 0, sr_in, pc_in, r15_in, vbr_in, 11, it))
                q.push_back(it);
            @(negedge clk);
            check("taken in commit", 11, {31'd0, taken}, 32'd1);
            @(negedge clk);
            check("taken after commit", 11, {31'd0, taken}, 32'd0);
            exc_pend = 0;
            @(negedge clk);
            @(negedge clk);
        end

        repeat (4) @(negedge clk);
        check("scoreboard drained", 11, q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule